// File: doc/BRIEF.md
# Ripple-Through Word Queue with Strobe Handshake

This block is a first-in first-out queue of 16 four-bit words. It is built as a line of single-word cells rather than a memory with read and write pointers. A word that is written enters the cell at the input end. It then walks toward the output end by one cell per clock, as long as the cell ahead of it is empty. Empty cells travel the other way, so the queued words always gather at the output end.

The writer and the reader each use a level strobe. The writer raises `wr_stb` when `in_rdy` is high. The word on `wr_data` is captured, and `in_rdy` falls to show the cell is busy. The word is released into the line only after the strobe has been sampled low again. The reader raises `rd_stb` while `out_vld` is high. The word at the output is consumed and `out_vld` falls. The flag rises again only once `rd_stb` is low and a further word sits in the output cell.

A synchronous reset empties the line but leaves the last output word in place. An active-low enable either presents that word or forces the data pins to zero, and it drives a separate "pins driven" qualifier.

Top module: `fthru_fifo`

## Requirements
- R1: The queue holds up to DEPTH (16) words of WIDTH (4) bits. Words leave in the order they were written, and every bit is passed through unchanged.
- R2: While `rst` is high, `in_rdy` reads 1 and `out_vld` reads 0. After one clocked reset cycle, every stored word is discarded and none of them later appears with `out_vld` high.
- R3: Reset leaves the output word unchanged. With `oe_n` low, `rd_data` keeps showing the last word that reached the output cell.
- R4: A clock edge that samples `wr_stb` high while `in_rdy` is high captures `wr_data` into the input cell. `in_rdy` is low in the following cycle.
- R5: The captured word stays in the input cell, with `in_rdy` low, for as long as `wr_stb` stays high. It may move on only at the edge after the one that first samples `wr_stb` low. `in_rdy` returns high once it has moved on.
- R6: If `wr_stb` is already high when reset is released, the word on `wr_data` is captured at the first clock edge after release.
- R7: When the input cell is occupied, a raised `wr_stb` is remembered only while it stays high. The load happens as soon as a free cell reaches the input end. If the strobe drops first, the request is discarded and the contents of the queue do not change.
- R8: While `out_vld` is high, `rd_data` carries a queued word, and that word does not change until a read takes it.
- R9: A clock edge that samples `rd_stb` high while `out_vld` is high consumes the output word. `out_vld` is low in the following cycle.
- R10: After a read, `out_vld` stays low for as long as `rd_stb` stays high. If the queue has emptied, `rd_data` keeps the word just read.
- R11: A word advances one cell per clock edge. Into an empty queue, `out_vld` rises DEPTH-1 edges after the edge that first samples `wr_stb` low.
- R12: With `oe_n` low, `rd_data` shows the output word and `rd_drive` is 1. With `oe_n` high, `rd_data` is 0 and `rd_drive` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Write strobe, level-sampled |
| rd_stb | input | 1 | Read strobe, level-sampled |
| oe_n | input | 1 | Active-low output enable |
| wr_data | input | WIDTH | Word to write |
| in_rdy | output | 1 | Input cell free, ready for a write |
| out_vld | output | 1 | Valid word present at the output |
| rd_data | output | WIDTH | Output word, zero while disabled |
| rd_drive | output | 1 | High when the output pins are enabled |

## Verification
Suppose an occupancy bit in the middle of the line is wrong. A word is then lost, duplicated or reordered, and this only shows up when the queue is drained. So the bench fills the queue to capacity and checks every word in order. Suppose instead that the input or output handshake flops go wrong. The flags then drop or rise one or more cycles too early. The bench therefore samples `in_rdy` and `out_vld` in the exact cycle after each strobe edge, and it times the fall-through latency from an empty queue to the edge. The reset cases are checked on the first cycle after release: a strobe held through reset, and output retention across reset.

// File: rtl/fthru_pkg.sv
package fthru_pkg;
  localparam int unsigned FT_WIDTH_DEF = 4;
  localparam int unsigned FT_DEPTH_DEF = 16;

  // Outcome of one strobe handshake unit for the current cycle.
  typedef struct packed {
    logic fire;   // action taken at the coming edge
    logic held;   // action already taken during this strobe level
  } hs_t;
endpackage

// File: rtl/ft_strobe_hs.sv
// Level strobe to single-action converter. An action fires once per high
// level of the strobe, at the first edge where the grant allows it. The
// "used" flop returns to zero only when the strobe is sampled low.
module ft_strobe_hs (
  input  logic clk,
  input  logic rst,
  input  logic level,
  input  logic grant,
  output logic fire,
  output logic held
);
  logic used_q;

  assign fire = level & ~used_q & grant;
  assign held = used_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      used_q <= 1'b0;
    end else if (!level) begin
      used_q <= 1'b0;
    end else if (fire) begin
      used_q <= 1'b1;
    end
  end
endmodule

// File: rtl/ft_chain.sv
// Line of single-word cells. Each cell carries an occupancy bit. A word
// moves forward when the cell ahead is empty, judged on the present state,
// so every word and every hole moves at most one cell per clock.
module ft_chain #(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] din,
  input  logic             consume,
  input  logic             head_lock,
  output logic [DEPTH-1:0] occ,
  output logic [WIDTH-1:0] tail_word
);
  localparam int unsigned LAST = DEPTH - 1;

  logic [DEPTH-2:0] move;
  logic [DEPTH-1:0] occ_nxt;
  logic [WIDTH-1:0] word_q [DEPTH];

  // Hand-off between neighbouring cells.
  for (genvar i = 0; i < DEPTH - 1; i++) begin : g_link
    if (i == 0) begin : g_head
      assign move[i] = occ[i] & ~occ[i+1] & ~head_lock;
    end else begin : g_body
      assign move[i] = occ[i] & ~occ[i+1];
    end
  end

  // Next occupancy for each cell.
  for (genvar i = 0; i < DEPTH; i++) begin : g_occ
    if (i == 0) begin : g_in
      assign occ_nxt[i] = (occ[i] & ~move[i]) | load;
    end else if (i == LAST) begin : g_out
      assign occ_nxt[i] = (occ[i] & ~consume) | move[i-1];
    end else begin : g_mid
      assign occ_nxt[i] = (occ[i] & ~move[i]) | move[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      occ <= '0;
    end else begin
      occ <= occ_nxt;
    end
  end

  // Word storage has no reset, so the output cell keeps its word across reset.
  always_ff @(posedge clk) begin
    if (load) begin
      word_q[0] <= din;
    end
    for (int i = 1; i < DEPTH; i++) begin
      if (move[i-1]) begin
        word_q[i] <= word_q[i-1];
      end
    end
  end

  assign tail_word = word_q[LAST];
endmodule

// File: rtl/fthru_fifo.sv
module fthru_fifo
  import fthru_pkg::*;
#(
  parameter int unsigned WIDTH = FT_WIDTH_DEF,
  parameter int unsigned DEPTH = FT_DEPTH_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_stb,
  input  logic             rd_stb,
  input  logic             oe_n,
  input  logic [WIDTH-1:0] wr_data,
  output logic             in_rdy,
  output logic             out_vld,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_drive
);
  localparam int unsigned LAST = DEPTH - 1;

  hs_t              wr_hs;
  hs_t              rd_hs;
  logic [DEPTH-1:0] occ;
  logic [WIDTH-1:0] tail_word;
  logic             head_free;
  logic             tail_full;

  assign head_free = ~occ[0];
  assign tail_full = occ[LAST];

  ft_strobe_hs u_wr (
    .clk   (clk),
    .rst   (rst),
    .level (wr_stb),
    .grant (head_free),
    .fire  (wr_hs.fire),
    .held  (wr_hs.held)
  );

  ft_strobe_hs u_rd (
    .clk   (clk),
    .rst   (rst),
    .level (rd_stb),
    .grant (tail_full),
    .fire  (rd_hs.fire),
    .held  (rd_hs.held)
  );

  ft_chain #(
    .WIDTH (WIDTH),
    .DEPTH (DEPTH)
  ) u_chain (
    .clk       (clk),
    .rst       (rst),
    .load      (wr_hs.fire),
    .din       (wr_data),
    .consume   (rd_hs.fire),
    .head_lock (wr_hs.held),
    .occ       (occ),
    .tail_word (tail_word)
  );

  // Flags are decoded from flops only; reset forces them while it is held.
  assign in_rdy   = rst | head_free;
  assign out_vld  = ~rst & tail_full & ~rd_hs.held;
  assign rd_data  = oe_n ? '0 : tail_word;
  assign rd_drive = ~oe_n;
endmodule

// File: rtl/ft_chk.sv
module ft_chk #(
  parameter int unsigned WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_stb,
  input logic             rd_stb,
  input logic             in_rdy,
  input logic             out_vld,
  input logic             wr_held,
  input logic             rd_held,
  input logic [WIDTH-1:0] tail_word
);
  a_r2_reset_flags: assert property (@(posedge clk)
    rst |-> (in_rdy && !out_vld));

  a_r4_load_busy: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && in_rdy) |=> !in_rdy);

  a_r5_head_hold: assert property (@(posedge clk) disable iff (rst)
    (wr_held && wr_stb) |=> !in_rdy);

  a_r9_read_take: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && out_vld) |=> !out_vld);

  a_r10_read_busy: assert property (@(posedge clk) disable iff (rst)
    (rd_held && rd_stb) |=> !out_vld);

  a_r8_word_steady: assert property (@(posedge clk) disable iff (rst)
    (out_vld && !rd_stb) |=> $stable(tail_word));
endmodule

bind fthru_fifo ft_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_stb    (wr_stb),
  .rd_stb    (rd_stb),
  .in_rdy    (in_rdy),
  .out_vld   (out_vld),
  .wr_held   (wr_hs.held),
  .rd_held   (rd_hs.held),
  .tail_word (tail_word)
);

// File: tb/sim_fthru_fifo.sv
module sim_fthru_fifo;
  localparam int W = 4;
  localparam int D = 16;
  localparam int WDOG = 20000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_stb = 1'b0;
  logic         rd_stb = 1'b0;
  logic         oe_n = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         in_rdy;
  logic         out_vld;
  logic [W-1:0] rd_data;
  logic         rd_drive;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  fthru_fifo #(.WIDTH(W), .DEPTH(D)) u0 (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .rd_stb(rd_stb), .oe_n(oe_n),
    .wr_data(wr_data), .in_rdy(in_rdy), .out_vld(out_vld),
    .rd_data(rd_data), .rd_drive(rd_drive)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WDOG) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // Vector table: bit 4 = 1 means write bits 3:0, 0 means read and expect bits 3:0.
  localparam logic [4:0] VEC [12] = '{
    5'h13, 5'h1C, 5'h03, 5'h17, 5'h0C, 5'h07,
    5'h10, 5'h1F, 5'h16, 5'h00, 5'h0F, 5'h06
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_rdy();
    int k = 0;
    while (!in_rdy && k < 200) begin tick(); k++; end
    chk("R5 in_rdy returns", int'(in_rdy), 1);
  endtask

  task automatic wait_vld();
    int k = 0;
    while (!out_vld && k < 200) begin tick(); k++; end
    chk("R8 out_vld arrives", int'(out_vld), 1);
  endtask

  task automatic push(input logic [W-1:0] d);
    wait_rdy();
    wr_data = d;
    wr_stb = 1'b1;
    tick();
    wr_stb = 1'b0;
    tick();
  endtask

  task automatic pop(input logic [W-1:0] exp, input string req);
    wait_vld();
    chk(req, int'(rd_data), int'(exp));
    rd_stb = 1'b1;
    tick();
    chk("R9 out_vld low after read", int'(out_vld), 0);
    rd_stb = 1'b0;
    tick();
  endtask

  initial begin
    // Reset state (R2)
    tick();
    tick();
    chk("R2 in_rdy in reset", int'(in_rdy), 1);
    chk("R2 out_vld in reset", int'(out_vld), 0);
    rst = 1'b0;
    tick();
    chk("R2 empty after reset", int'(out_vld), 0);

    // Load, hold, latency (R4, R5, R11)
    wr_data = 4'hB;
    wr_stb = 1'b1;
    tick();
    chk("R4 in_rdy busy after load", int'(in_rdy), 0);
    tick();
    tick();
    chk("R5 word held while strobe high", int'(in_rdy), 0);
    chk("R5 nothing at output while held", int'(out_vld), 0);
    wr_stb = 1'b0;
    tick();
    begin
      int n = 0;
      while (!out_vld && n < 100) begin tick(); n++; end
      chk("R11 fall-through edges", n, D - 1);
    end
    chk("R5 in_rdy high after move", int'(in_rdy), 1);
    chk("R8 output word", int'(rd_data), 'hB);

    // Read with strobe held on an emptying queue (R9, R10)
    rd_stb = 1'b1;
    tick();
    chk("R9 out_vld low after read", int'(out_vld), 0);
    tick();
    tick();
    chk("R10 out_vld low while strobe held", int'(out_vld), 0);
    chk("R10 last word kept", int'(rd_data), 'hB);
    rd_stb = 1'b0;
    tick();
    chk("R10 empty stays invalid", int'(out_vld), 0);

    // Table walk (R1, R8)
    foreach (VEC[i]) begin
      if (VEC[i][4]) push(VEC[i][3:0]);
      else           pop(VEC[i][3:0], "R1 table order");
    end

    // Capacity and dropped request (R1, R7)
    for (int i = 0; i < D; i++) push(W'(i ^ 5));
    repeat (20) tick();
    chk("R1 full after DEPTH writes", int'(in_rdy), 0);
    wr_data = 4'hE;
    wr_stb = 1'b1;
    tick();
    wr_stb = 1'b0;
    tick();
    chk("R7 no room when full", int'(in_rdy), 0);
    for (int i = 0; i < D; i++) pop(W'(i ^ 5), "R1 full drain order");
    repeat (20) tick();
    chk("R7 dropped request left no word", int'(out_vld), 0);

    // Strobe held on full queue (R7)
    for (int i = 0; i < D; i++) push(W'(i ^ 9));
    wr_data = 4'hA;
    wr_stb = 1'b1;
    tick();
    chk("R7 held strobe waits", int'(in_rdy), 0);
    pop(W'(0 ^ 9), "R7 first word");
    repeat (40) tick();
    wr_stb = 1'b0;
    tick();
    for (int i = 1; i < D; i++) pop(W'(i ^ 9), "R7 old words");
    pop(4'hA, "R7 pending word loaded");

    // Strobe high through reset (R6)
    rst = 1'b1;
    wr_data = 4'h5;
    wr_stb = 1'b1;
    tick();
    tick();
    chk("R2 in_rdy forced in reset", int'(in_rdy), 1);
    rst = 1'b0;
    tick();
    chk("R6 load at first edge", int'(in_rdy), 0);
    wr_stb = 1'b0;
    pop(4'h5, "R6 word loaded at release");

    // Output retained over reset, stored words discarded (R2, R3)
    push(4'h9);
    push(4'h3);
    wait_vld();
    chk("R8 output before reset", int'(rd_data), 9);
    rst = 1'b1;
    tick();
    tick();
    chk("R2 out_vld low in reset", int'(out_vld), 0);
    chk("R3 word kept in reset", int'(rd_data), 9);
    rst = 1'b0;
    repeat (30) tick();
    chk("R2 words discarded", int'(out_vld), 0);
    chk("R3 word kept after reset", int'(rd_data), 9);

    // Output enable (R12)
    oe_n = 1'b1;
    tick();
    chk("R12 data zero when disabled", int'(rd_data), 0);
    chk("R12 drive low when disabled", int'(rd_drive), 0);
    oe_n = 1'b0;
    tick();
    chk("R12 data back when enabled", int'(rd_data), 9);
    chk("R12 drive high when enabled", int'(rd_drive), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule